// File: doc/BRIEF.md
# Wait-State Flash Read Front End

This block connects a 32-bit processor-side read bus to a wide flash array port. On a read it checks whether the addressed line is already held locally. If it is, the read completes in the same cycle. If it is not, the block fetches the line from the array and holds the array request for a programmable number of extra cycles. It then returns the requested byte, halfword or word and keeps the fetched line for later reads.

The fetch width is 128 bits by default. A mode input switches it to 64 bits, for systems that favour lower array power over hit rate. The flash holds 1 MiB, but the reserved window is larger. Only the low 20 address bits are decoded, so the flash contents repeat across the window.

The bus master raises `bus_req` and holds `bus_addr` and `bus_size` steady until it sees `bus_rdy`. The array model drives `arr_rdata` from `arr_addr`. The block samples that data in the last cycle of a fetch.

Top module: `flash_rd_front`

## Requirements
- R1: Out of reset no line is held, so the first read is a miss. `bus_rdy` is only ever high while `bus_req` is high. After reset, with no request, `bus_rdy` and `arr_req` are both low.
- R2: On a miss, `bus_rdy` stays low for exactly `cfg_wait + 1` cycles, counting the request cycle, and rises in the following cycle. With `cfg_wait = 0` a miss costs exactly one stall cycle.
- R3: During a miss, `arr_req` is high for exactly `cfg_wait + 1` consecutive cycles, starting in the cycle after the request. While it is high, `arr_addr` holds the line-aligned, aliased byte address and does not change.
- R4: A read whose aligned line address matches the held, valid line completes in the request cycle, with no stall and no array request.
- R5: With `cfg_narrow = 1`, lines are 8 bytes. Only `arr_rdata[63:0]` is used, and `arr_wide` is low during fetches. An address in the other 8-byte half of a 16-byte block misses.
- R6: With `cfg_narrow = 0`, which is the reset-default fetch width, lines are 16 bytes and `arr_wide` is high during fetches. Any offset within the 16-byte line hits after one fetch.
- R7: Address bits 31..20 are ignored. The address A + k·0x10_0000 reads the same data as A, and hits the line held for A.
- R8: `bus_size` selects the access width: 0 is a byte, 1 is a halfword and 2 is a word. Bytes are taken little-endian, from the lane given by the low address bits. Byte and halfword results are zero-extended onto `bus_rdata`.
- R9: Any change of `cfg_wait` or `cfg_narrow` invalidates the held line, so the next read of that line misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | 4 | Extra array cycles per fetch |
| cfg_narrow | input | 1 | 1 selects 64-bit fetches, 0 selects 128-bit fetches |
| bus_req | input | 1 | Read request, held until `bus_rdy` |
| bus_addr | input | 32 | Byte address of the read |
| bus_size | input | 2 | 0 for byte, 1 for halfword, 2 for word |
| bus_rdy | output | 1 | Read completes in this cycle |
| bus_rdata | output | 32 | Zero-extended read data |
| arr_req | output | 1 | Array fetch in progress |
| arr_addr | output | 20 | Line-aligned array byte address |
| arr_wide | output | 1 | 1 for a 128-bit fetch, 0 for a 64-bit fetch |
| arr_rdata | input | 128 | Array line data |

## Verification
The checker watches the timing envelope on every cycle:
- a stall never runs past `cfg_wait + 1` cycles;
- `bus_rdy` never rises without a request;
- the array address stays aligned and stable during a fetch;
- `arr_wide` follows the mode bit.

Some behaviour can only be shown by the bench's directed scenarios:
- a stall that is exactly as long as required, rather than merely no longer;
- reads that hit the held line without an array request;
- correct lane selection and zero-extension;
- alias hits;
- line invalidation after a configuration change.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    localparam int FLASH_AW   = 20;
    localparam int LINE_W     = 128;
    localparam int BUS_W      = 32;
    localparam int WAIT_W     = 4;
    localparam int LINE_BYTES = LINE_W / 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int WORDS      = LINE_W / BUS_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } fetch_st_e;

    // Align an aliased byte address down to the start of its line.
    function automatic logic [FLASH_AW-1:0] line_base(
        input logic [FLASH_AW-1:0] a,
        input logic                narrow
    );
        logic [FLASH_AW-1:0] m;
        m = narrow ? FLASH_AW'(LINE_BYTES / 2 - 1) : FLASH_AW'(LINE_BYTES - 1);
        return a & ~m;
    endfunction

    // Offset of the addressed byte within the current line.
    function automatic logic [OFF_W-1:0] line_off(
        input logic [FLASH_AW-1:0] a,
        input logic                narrow
    );
        logic [OFF_W-1:0] o;
        o = a[OFF_W-1:0];
        if (narrow) o[OFF_W-1] = 1'b0;
        return o;
    endfunction

endpackage

// File: rtl/frd_wait_ctr.sv
module frd_wait_ctr
    import flash_rd_pkg::*;
#(
    parameter int CW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] wait_val,
    output logic          busy,
    output logic          last
);
    fetch_st_e     st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (st_q == ST_IDLE) begin
            if (start) begin
                st_q  <= ST_FETCH;
                cnt_q <= wait_val;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            st_q <= ST_IDLE;
        end
    end

    assign busy = (st_q == ST_FETCH);
    assign last = busy && (cnt_q == '0);
endmodule

// File: rtl/frd_line_hold.sv
module frd_line_hold
    import flash_rd_pkg::*;
#(
    parameter int AW = FLASH_AW,
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          capture,
    input  logic [AW-1:0] cap_base,
    input  logic [LW-1:0] cap_line,
    input  logic [AW-1:0] look_base,
    output logic          hit,
    output logic [LW-1:0] line_out
);
    logic          vld_q;
    logic [AW-1:0] base_q;
    logic [LW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            base_q <= '0;
            data_q <= '0;
        end else begin
            if (flush)        vld_q <= 1'b0;
            else if (capture) vld_q <= 1'b1;
            if (capture) begin
                base_q <= cap_base;
                data_q <= cap_line;
            end
        end
    end

    assign hit      = vld_q && (base_q == look_base);
    assign line_out = data_q;
endmodule

// File: rtl/frd_lane_mux.sv
module frd_lane_mux
    import flash_rd_pkg::*;
#(
    parameter int LW = LINE_W,
    parameter int BW = BUS_W
) (
    input  logic [LW-1:0]           src,
    input  logic [$clog2(LW/8)-1:0] off,
    input  logic [1:0]              size,
    output logic [BW-1:0]           data
);
    localparam int NW  = LW / BW;
    localparam int OW  = $clog2(LW / 8);
    localparam int BOW = $clog2(BW / 8);

    logic [BW-1:0] words [NW];
    logic [BW-1:0] w;

    genvar gi;
    generate
        for (gi = 0; gi < NW; gi++) begin : g_split
            assign words[gi] = src[gi*BW +: BW];
        end
    endgenerate

    always_comb begin
        w = words[off[OW-1:BOW]];
        unique case (size)
            SZ_BYTE: data = BW'(w[8*off[BOW-1:0] +: 8]);
            SZ_HALF: data = BW'(w[16*off[BOW-1] +: 16]);
            default: data = w;
        endcase
    end
endmodule

// File: rtl/flash_rd_front.sv
module flash_rd_front
    import flash_rd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [WAIT_W-1:0]   cfg_wait,
    input  logic                cfg_narrow,
    input  logic                bus_req,
    input  logic [31:0]         bus_addr,
    input  logic [1:0]          bus_size,
    output logic                bus_rdy,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                arr_req,
    output logic [FLASH_AW-1:0] arr_addr,
    output logic                arr_wide,
    input  logic [LINE_W-1:0]   arr_rdata
);
    logic [WAIT_W-1:0]   wait_q;
    logic                narrow_q;
    logic                cfg_change;
    logic [FLASH_AW-1:0] alias_a;
    logic [FLASH_AW-1:0] look_base;
    logic [FLASH_AW-1:0] fetch_base_q;
    logic                hit, hit_ok, busy, last, start;
    logic [LINE_W-1:0]   held_line, src_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q       <= '0;
            narrow_q     <= 1'b0;
            fetch_base_q <= '0;
        end else begin
            wait_q   <= cfg_wait;
            narrow_q <= cfg_narrow;
            if (start) fetch_base_q <= look_base;
        end
    end

    assign cfg_change = (cfg_wait != wait_q) || (cfg_narrow != narrow_q);
    assign alias_a    = bus_addr[FLASH_AW-1:0];
    assign look_base  = line_base(alias_a, cfg_narrow);
    assign hit_ok     = hit && !cfg_change;
    assign start      = bus_req && !busy && !hit_ok;

    frd_wait_ctr #(.CW(WAIT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .wait_val (cfg_wait),
        .busy     (busy),
        .last     (last)
    );

    frd_line_hold #(.AW(FLASH_AW), .LW(LINE_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_change),
        .capture   (last),
        .cap_base  (fetch_base_q),
        .cap_line  (arr_rdata),
        .look_base (look_base),
        .hit       (hit),
        .line_out  (held_line)
    );

    assign src_line = busy ? arr_rdata : held_line;

    frd_lane_mux #(.LW(LINE_W), .BW(BUS_W)) u_mux (
        .src  (src_line),
        .off  (line_off(alias_a, cfg_narrow)),
        .size (bus_size),
        .data (bus_rdata)
    );

    assign bus_rdy  = bus_req && (busy ? last : hit_ok);
    assign arr_req  = busy;
    assign arr_addr = fetch_base_q;
    assign arr_wide = !cfg_narrow;
endmodule

// File: rtl/flash_rd_front_chk.sv
module flash_rd_front_chk
    import flash_rd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [WAIT_W-1:0]   cfg_wait,
    input logic                cfg_narrow,
    input logic                bus_req,
    input logic                bus_rdy,
    input logic                arr_req,
    input logic [FLASH_AW-1:0] arr_addr,
    input logic                arr_wide
);
    logic [WAIT_W:0] stall_cnt;

    always_ff @(posedge clk) begin
        if (rst)                      stall_cnt <= '0;
        else if (bus_req && !bus_rdy) stall_cnt <= stall_cnt + 1'b1;
        else                          stall_cnt <= '0;
    end

    a_r1_rdy_needs_req: assert property (@(posedge clk) disable iff (rst)
        bus_rdy |-> bus_req);

    a_r2_stall_bounded: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_rdy) |-> (stall_cnt <= {1'b0, cfg_wait}));

    a_r3_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        arr_req |-> ((arr_addr & (cfg_narrow ? FLASH_AW'(7) : FLASH_AW'(15))) == '0));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (arr_req && $past(arr_req)) |-> $stable(arr_addr));

    a_r6_width_follows_mode: assert property (@(posedge clk) disable iff (rst)
        arr_req |-> (arr_wide == !cfg_narrow));
endmodule

bind flash_rd_front flash_rd_front_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wait   (cfg_wait),
    .cfg_narrow (cfg_narrow),
    .bus_req    (bus_req),
    .bus_rdy    (bus_rdy),
    .arr_req    (arr_req),
    .arr_addr   (arr_addr),
    .arr_wide   (arr_wide)
);

// File: tb/flash_rd_front_bench.sv
`timescale 1ns/1ps
module flash_rd_front_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   cfg_wait = 4'd0;
    logic         cfg_narrow = 1'b0;
    logic         bus_req = 1'b0;
    logic [31:0]  bus_addr = '0;
    logic [1:0]   bus_size = 2'd0;
    logic         bus_rdy;
    logic [31:0]  bus_rdata;
    logic         arr_req;
    logic [19:0]  arr_addr;
    logic         arr_wide;
    logic [127:0] arr_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_rd_front u_flash_rd_front (
        .clk(clk), .rst(rst), .cfg_wait(cfg_wait), .cfg_narrow(cfg_narrow),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .arr_req(arr_req),
        .arr_addr(arr_addr), .arr_wide(arr_wide), .arr_rdata(arr_rdata)
    );

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        logic [19:0] f;
        f = a[19:0];
        return 8'(f[7:0] * 8'd13 + f[15:8] + {4'd0, f[19:16]} * 8'd5);
    endfunction

    always_comb begin
        for (int i = 0; i < 16; i++)
            arr_rdata[8*i +: 8] = byte_at({12'd0, arr_addr} + 32'(i));
    end

    function automatic logic [31:0] exp_data(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] b;
        case (sz)
            2'd0: return {24'd0, byte_at(a)};
            2'd1: begin b = {a[31:1], 1'b0}; return {16'd0, byte_at(b + 1), byte_at(b)}; end
            default: begin
                b = {a[31:2], 2'b00};
                return {byte_at(b + 3), byte_at(b + 2), byte_at(b + 1), byte_at(b)};
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One read: checks stall length, array cycles, fetch address, width and data.
    task automatic rd(input logic [31:0] a, input logic [1:0] sz, input int exp_stall,
                      input logic [19:0] exp_base, input string req);
        int stall = 0;
        int fcyc = 0;
        logic [19:0] seen_base = '0;
        logic        seen_wide = 1'b0;
        @(negedge clk);
        bus_req = 1'b1; bus_addr = a; bus_size = sz;
        #1;
        while (!bus_rdy && stall < 40) begin
            if (arr_req) begin fcyc++; seen_base = arr_addr; seen_wide = arr_wide; end
            stall++;
            @(negedge clk); #1;
        end
        if (arr_req) begin fcyc++; seen_base = arr_addr; seen_wide = arr_wide; end
        check({req, " stall"}, 32'(stall), 32'(exp_stall));
        check({req, " array cycles"}, 32'(fcyc), 32'(exp_stall));
        check({req, " data"}, bus_rdata, exp_data(a, sz));
        if (exp_stall != 0) begin
            check({req, " fetch addr"}, {12'd0, seen_base}, {12'd0, exp_base});
            check({req, " fetch width"}, {31'd0, seen_wide}, {31'd0, !cfg_narrow});
        end
    endtask

    task automatic set_cfg(input logic [3:0] w, input logic n);
        @(negedge clk);
        bus_req = 1'b0; cfg_wait = w; cfg_narrow = n;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        #1;
        check("R1 rdy idle", {31'd0, bus_rdy}, 32'd0);
        check("R1 arr_req idle", {31'd0, arr_req}, 32'd0);
        rd(32'h0000_0040, 2'd2, 1, 20'h00040, "R1 first read misses");
    endtask

    task automatic t_wait_states;
        set_cfg(4'd0, 1'b0);
        rd(32'h0000_1000, 2'd2, 1, 20'h01000, "R2 wait0");
        set_cfg(4'd3, 1'b0);
        rd(32'h0000_2004, 2'd2, 4, 20'h02000, "R2 wait3");
        set_cfg(4'd7, 1'b0);
        rd(32'h0000_3008, 2'd2, 8, 20'h03000, "R3 wait7");
        set_cfg(4'd15, 1'b0);
        rd(32'h0000_400C, 2'd2, 16, 20'h04000, "R3 wait15");
    endtask

    task automatic t_hits_wide;
        set_cfg(4'd2, 1'b0);
        rd(32'h0000_5000, 2'd2, 3, 20'h05000, "R6 wide miss");
        rd(32'h0000_500C, 2'd2, 0, 20'h0, "R4 hit word3");
        rd(32'h0000_5008, 2'd2, 0, 20'h0, "R6 hit upper half");
        rd(32'h0000_5010, 2'd2, 3, 20'h05010, "R4 next line misses");
    endtask

    task automatic t_lanes;
        set_cfg(4'd1, 1'b0);
        rd(32'h0000_6120, 2'd0, 2, 20'h06120, "R8 byte0 miss");
        for (int i = 1; i < 16; i++)
            rd(32'h0000_6120 + 32'(i), 2'd0, 0, 20'h0, "R8 byte lane");
        for (int i = 0; i < 16; i += 2)
            rd(32'h0000_6120 + 32'(i), 2'd1, 0, 20'h0, "R8 halfword lane");
        for (int i = 0; i < 16; i += 4)
            rd(32'h0000_6120 + 32'(i), 2'd2, 0, 20'h0, "R8 word lane");
    endtask

    task automatic t_alias;
        set_cfg(4'd1, 1'b0);
        rd(32'h0000_7010, 2'd2, 2, 20'h07010, "R7 base miss");
        rd(32'h0030_7014, 2'd2, 0, 20'h0, "R7 alias hit");
        rd(32'hFFF0_701B, 2'd0, 0, 20'h0, "R7 high alias byte");
        rd(32'h0010_8000, 2'd2, 2, 20'h08000, "R7 alias miss addr");
    endtask

    task automatic t_narrow;
        set_cfg(4'd1, 1'b1);
        rd(32'h0000_9100, 2'd2, 2, 20'h09100, "R5 narrow miss");
        rd(32'h0000_9106, 2'd1, 0, 20'h0, "R5 narrow hit");
        rd(32'h0000_9108, 2'd2, 2, 20'h09108, "R5 other half misses");
        rd(32'h0000_910F, 2'd0, 0, 20'h0, "R5 narrow byte");
    endtask

    task automatic t_invalidate;
        set_cfg(4'd2, 1'b0);
        rd(32'h0000_A000, 2'd2, 3, 20'h0A000, "R9 load");
        rd(32'h0000_A004, 2'd2, 0, 20'h0, "R9 held");
        set_cfg(4'd3, 1'b0);
        rd(32'h0000_A004, 2'd2, 4, 20'h0A000, "R9 wait change misses");
        set_cfg(4'd3, 1'b1);
        rd(32'h0000_A004, 2'd2, 4, 20'h0A000, "R9 width change misses");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wait_states();
        t_hits_wide();
        t_lanes();
        t_alias();
        t_narrow();
        t_invalidate();
        @(negedge clk);
        bus_req = 1'b0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule